// File: doc/BRIEF.md
# Configuration Port Unlock Controller

This block sits on a byte-wide host I/O bus and implements a two-port index/data configuration interface. A host first writes a fixed four-byte key to the index port. After that, each index-port write picks a configuration register, and data-port accesses read or write the chosen register. A device-select register picks which bank of per-device registers the upper indices reach. Each bank holds an activate bit and a 16-bit base address. The block also presents a fixed chip identifier and revision.

Writing the value 0x02 to configuration index 0x02 locks the interface again. While the interface is locked, the data port reads 0xFF and ignores writes. The activate bits and base addresses drive the block's outputs, so the device functions around it can be enabled and placed.

Top module: `cfg_unlock_port`

## Requirements
- R1: After reset the interface is locked, the index and device-select registers are 0, and every device has activate 0 and base address 0.
- R2: The writes 0x87, 0x01, 0x55, 0x55 to the index port (address 0x2E), in that order, unlock the interface. `cfgMode` rises in the cycle after the fourth write.
- R3: While locked, any index-port byte that does not match the expected key byte restarts the match from the beginning. A 0x87 byte restarts it at step one. Writes to other addresses do not disturb the match.
- R4: While locked, data-port (0x2F) reads return 0xFF and data-port writes change nothing.
- R5: While unlocked, an index-port write loads the index register, and an index-port read returns it. While locked, an index-port read returns 0xFF.
- R6: Index 0x20 reads the chip ID high byte and 0x21 reads the low byte. Index 0x22 reads the revision in bits 3:0, with bits 7:4 at zero.
- R7: Index 0x07 is the device-select register and can be read and written. Its value chooses the device bank that indices 0x30, 0x60 and 0x61 address.
- R8: For the selected device, index 0x30 stores bit 0 of the written value as the activate bit. It reads back as {7'b0, bit}, and the bit drives `devActive`.
- R9: For the selected device, index 0x60 holds the base address high byte and 0x61 the low byte. `devBaseValid` is 1 exactly when that 16-bit address is nonzero.
- R10: A data write of 0x02 while the index is 0x02 locks the interface in the next cycle and clears the index. A different value written at index 0x02 leaves the interface unlocked.
- R11: Unimplemented indices read 0x00. When the device-select value is NUM_DEV or higher, device indices read 0x00 and writes to them are ignored.
- R12: Writes to the chip ID and revision indices have no effect.
- R13: A read of any address other than the two ports returns 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ioAddr | input | 16 | Host I/O address |
| ioWr | input | 1 | Write strobe, one cycle per byte |
| ioRd | input | 1 | Read strobe |
| ioWrData | input | 8 | Write data byte |
| ioRdData | output | 8 | Read data, combinational from address and state |
| cfgMode | output | 1 | Interface is unlocked |
| devActive | output | NUM_DEV | Activate bit per device |
| devBase | output | NUM_DEV*16 | Base address per device, device i at bits 16i+15:16i |
| devBaseValid | output | NUM_DEV | Base address of device i is nonzero |

## Verification
The key matcher is driven with the exact key, with a key broken by a wrong byte in the last position, with a repeated 0x87 and a repeated 0x87 0x01 prefix, and with foreign-address writes interleaved. These cases separate a correct restart rule from one that only resets to zero or that counts any bus write. Register traffic goes to two different device banks, so a bank select that is ignored shows up as a cross-bank corruption. Out-of-range device numbers and read-only indices show whether writes escape their guards. The exit register is written first with a non-matching value and then with the real one, which separates a decode that checks the value from one that acts on the index alone.

// File: rtl/cfg_unlock_pkg.sv
package cfg_unlock_pkg;

  typedef struct packed {
    logic idxLoad;   // index register takes the write byte
    logic regWrite;  // data-port write to the selected register
    logic exitNow;   // lock request seen this cycle
  } cfgStrobe_t;

  localparam logic [7:0] IDX_EXIT   = 8'h02;
  localparam logic [7:0] IDX_DEVSEL = 8'h07;
  localparam logic [7:0] IDX_IDHI   = 8'h20;
  localparam logic [7:0] IDX_IDLO   = 8'h21;
  localparam logic [7:0] IDX_REV    = 8'h22;
  localparam logic [7:0] IDX_ACT    = 8'h30;
  localparam logic [7:0] IDX_BASEHI = 8'h60;
  localparam logic [7:0] IDX_BASELO = 8'h61;
  localparam logic [7:0] EXIT_VAL   = 8'h02;
  localparam logic [7:0] KEY_FIRST  = 8'h87;

  function automatic logic [7:0] keyByte(input logic [1:0] pos);
    case (pos)
      2'd0:    keyByte = 8'h87;
      2'd1:    keyByte = 8'h01;
      default: keyByte = 8'h55;
    endcase
  endfunction

endpackage

// File: rtl/cfg_unlock_ctrl.sv
module cfg_unlock_ctrl
  import cfg_unlock_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] INDEX_ADDR = 16'h002E,
  parameter logic [ADDR_W-1:0] DATA_ADDR  = 16'h002F
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic              ioWr,
  input  logic [7:0]        ioWrData,
  input  logic [7:0]        curIndex,
  output cfgStrobe_t        strobe,
  output logic              unlocked
);

  logic [1:0] keyPos;
  logic       idxWr;
  logic       dataWr;
  logic       keyHit;

  assign idxWr  = ioWr && (ioAddr == INDEX_ADDR);
  assign dataWr = ioWr && (ioAddr == DATA_ADDR);
  assign keyHit = (ioWrData == keyByte(keyPos));

  always_comb begin
    strobe.idxLoad  = unlocked && idxWr;
    strobe.regWrite = unlocked && dataWr;
    strobe.exitNow  = unlocked && dataWr && (curIndex == IDX_EXIT) && (ioWrData == EXIT_VAL);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      keyPos   <= 2'd0;
      unlocked <= 1'b0;
    end else if (!unlocked) begin
      if (idxWr) begin
        if (keyHit) begin
          if (keyPos == 2'd3) begin
            unlocked <= 1'b1;
            keyPos   <= 2'd0;
          end else begin
            keyPos <= keyPos + 2'd1;
          end
        end else if (ioWrData == KEY_FIRST) begin
          keyPos <= 2'd1;
        end else begin
          keyPos <= 2'd0;
        end
      end
    end else if (strobe.exitNow) begin
      unlocked <= 1'b0;
      keyPos   <= 2'd0;
    end
  end

endmodule

// File: rtl/cfg_unlock_dpath.sv
module cfg_unlock_dpath
  import cfg_unlock_pkg::*;
#(
  parameter int NUM_DEV = 16,
  parameter logic [15:0] CHIP_ID = 16'h8716,
  parameter logic [3:0]  CHIP_REV = 4'h3
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  cfgStrobe_t            strobe,
  input  logic [7:0]            ioWrData,
  output logic [7:0]            curIndex,
  output logic [7:0]            regRdData,
  output logic [NUM_DEV-1:0]    devActive,
  output logic [NUM_DEV*16-1:0] devBase,
  output logic [NUM_DEV-1:0]    devBaseValid
);

  localparam int SEL_W = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1;

  logic [7:0]       devSel;
  logic             selInRange;
  logic [SEL_W-1:0] selIdx;

  assign selInRange = (devSel < 8'(NUM_DEV));
  assign selIdx     = devSel[SEL_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curIndex <= 8'h00;
      devSel   <= 8'h00;
    end else begin
      if (strobe.exitNow) curIndex <= 8'h00;
      else if (strobe.idxLoad) curIndex <= ioWrData;
      if (strobe.regWrite && curIndex == IDX_DEVSEL) devSel <= ioWrData;
    end
  end

  for (genvar d = 0; d < NUM_DEV; d++) begin : g_bank
    logic bankHit;
    assign bankHit = strobe.regWrite && selInRange && (devSel == 8'(d));
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        devActive[d]          <= 1'b0;
        devBase[d*16 +: 16]   <= 16'h0000;
      end else if (bankHit) begin
        if (curIndex == IDX_ACT)    devActive[d]        <= ioWrData[0];
        if (curIndex == IDX_BASEHI) devBase[d*16+8 +: 8] <= ioWrData;
        if (curIndex == IDX_BASELO) devBase[d*16 +: 8]   <= ioWrData;
      end
    end
    assign devBaseValid[d] = |devBase[d*16 +: 16];
  end

  logic [15:0] selBase;
  logic        selAct;
  assign selBase = selInRange ? devBase[selIdx*16 +: 16] : 16'h0000;
  assign selAct  = selInRange ? devActive[selIdx] : 1'b0;

  always_comb begin
    case (curIndex)
      IDX_DEVSEL: regRdData = devSel;
      IDX_IDHI:   regRdData = CHIP_ID[15:8];
      IDX_IDLO:   regRdData = CHIP_ID[7:0];
      IDX_REV:    regRdData = {4'h0, CHIP_REV};
      IDX_ACT:    regRdData = {7'h00, selAct};
      IDX_BASEHI: regRdData = selBase[15:8];
      IDX_BASELO: regRdData = selBase[7:0];
      default:    regRdData = 8'h00;
    endcase
  end

endmodule

// File: rtl/cfg_unlock_port.sv
module cfg_unlock_port
  import cfg_unlock_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] INDEX_ADDR = 16'h002E,
  parameter logic [ADDR_W-1:0] DATA_ADDR  = 16'h002F,
  parameter int NUM_DEV = 16,
  parameter logic [15:0] CHIP_ID = 16'h8716,
  parameter logic [3:0]  CHIP_REV = 4'h3
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [ADDR_W-1:0]     ioAddr,
  input  logic                  ioWr,
  input  logic                  ioRd,
  input  logic [7:0]            ioWrData,
  output logic [7:0]            ioRdData,
  output logic                  cfgMode,
  output logic [NUM_DEV-1:0]    devActive,
  output logic [NUM_DEV*16-1:0] devBase,
  output logic [NUM_DEV-1:0]    devBaseValid
);

  cfgStrobe_t strobe;
  logic [7:0] curIndex;
  logic [7:0] regRdData;

  cfg_unlock_ctrl #(
    .ADDR_W(ADDR_W), .INDEX_ADDR(INDEX_ADDR), .DATA_ADDR(DATA_ADDR)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .ioAddr(ioAddr), .ioWr(ioWr),
    .ioWrData(ioWrData), .curIndex(curIndex), .strobe(strobe), .unlocked(cfgMode)
  );

  cfg_unlock_dpath #(
    .NUM_DEV(NUM_DEV), .CHIP_ID(CHIP_ID), .CHIP_REV(CHIP_REV)
  ) uDpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .ioWrData(ioWrData),
    .curIndex(curIndex), .regRdData(regRdData), .devActive(devActive),
    .devBase(devBase), .devBaseValid(devBaseValid)
  );

  always_comb begin
    ioRdData = 8'hFF;
    if (ioRd && cfgMode) begin
      if (ioAddr == DATA_ADDR)       ioRdData = regRdData;
      else if (ioAddr == INDEX_ADDR) ioRdData = curIndex;
    end
  end

endmodule

// File: rtl/cfg_unlock_chk.sv
module cfg_unlock_chk #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] INDEX_ADDR = 16'h002E,
  parameter logic [ADDR_W-1:0] DATA_ADDR  = 16'h002F,
  parameter int NUM_DEV = 16
) (
  input logic                  clk,
  input logic                  rstN,
  input logic [ADDR_W-1:0]     ioAddr,
  input logic                  ioWr,
  input logic                  ioRd,
  input logic [7:0]            ioWrData,
  input logic [7:0]            ioRdData,
  input logic                  cfgMode,
  input logic [NUM_DEV-1:0]    devActive,
  input logic [NUM_DEV*16-1:0] devBase
);

  a_r2_unlock_on_key: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cfgMode) |-> $past(ioWr && ioAddr == INDEX_ADDR && ioWrData == 8'h55));

  a_r10_lock_on_exit: assert property (@(posedge clk) disable iff (!rstN)
    $fell(cfgMode) |-> $past(ioWr && ioAddr == DATA_ADDR && ioWrData == 8'h02));

  a_r4_locked_data_read: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgMode && ioRd && ioAddr == DATA_ADDR) |-> ioRdData == 8'hFF);

  a_r5_locked_index_read: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgMode && ioRd && ioAddr == INDEX_ADDR) |-> ioRdData == 8'hFF);

  a_r4_locked_regs_hold: assert property (@(posedge clk) disable iff (!rstN)
    !cfgMode |=> ($stable(devActive) && $stable(devBase)));

  a_r13_foreign_read: assert property (@(posedge clk) disable iff (!rstN)
    (ioRd && ioAddr != INDEX_ADDR && ioAddr != DATA_ADDR) |-> ioRdData == 8'hFF);

endmodule

bind cfg_unlock_port cfg_unlock_chk #(
  .ADDR_W(ADDR_W), .INDEX_ADDR(INDEX_ADDR), .DATA_ADDR(DATA_ADDR), .NUM_DEV(NUM_DEV)
) uChk (
  .clk(clk), .rstN(rstN), .ioAddr(ioAddr), .ioWr(ioWr), .ioRd(ioRd),
  .ioWrData(ioWrData), .ioRdData(ioRdData), .cfgMode(cfgMode),
  .devActive(devActive), .devBase(devBase)
);

// File: tb/cfg_unlock_port_test.sv
module cfg_unlock_port_test;
  localparam int CLK_PERIOD = 10;
  localparam int NDEV = 16;
  localparam logic [15:0] IDXP = 16'h002E;
  localparam logic [15:0] DATP = 16'h002F;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [15:0] ioAddr = 16'h0;
  logic ioWr = 1'b0, ioRd = 1'b0;
  logic [7:0] ioWrData = 8'h0;
  logic [7:0] ioRdData;
  logic cfgMode;
  logic [NDEV-1:0] devActive, devBaseValid;
  logic [NDEV*16-1:0] devBase;

  int runCnt = 0, failCnt = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_unlock_port uut (
    .clk(clk), .rstN(rstN), .ioAddr(ioAddr), .ioWr(ioWr), .ioRd(ioRd),
    .ioWrData(ioWrData), .ioRdData(ioRdData), .cfgMode(cfgMode),
    .devActive(devActive), .devBase(devBase), .devBaseValid(devBaseValid)
  );

  // behavioural reference state
  bit mLocked = 1;
  int mStep = 0;
  int mIdx = 0, mSel = 0;
  int mAct[NDEV];
  int mBase[NDEV];
  int keyQ[$] = '{'h87, 'h01, 'h55, 'h55};

  task automatic check(bit ok, string tag, int act, int exp);
    runCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int mRead(int addr);
    if (addr != DATP && addr != IDXP) return 'hFF;
    if (mLocked) return 'hFF;
    if (addr == IDXP) return mIdx;
    case (mIdx)
      'h07: return mSel;
      'h20: return 'h87;
      'h21: return 'h16;
      'h22: return 'h03;
      'h30: return (mSel < NDEV) ? mAct[mSel] : 0;
      'h60: return (mSel < NDEV) ? (mBase[mSel] >> 8) : 0;
      'h61: return (mSel < NDEV) ? (mBase[mSel] & 'hFF) : 0;
      default: return 0;
    endcase
  endfunction

  function automatic void mWrite(int addr, int d);
    if (addr == IDXP) begin
      if (mLocked) begin
        if (d == keyQ[mStep]) begin
          mStep++;
          if (mStep == 4) begin mLocked = 0; mStep = 0; end
        end else mStep = (d == 'h87) ? 1 : 0;
      end else mIdx = d;
    end else if (addr == DATP && !mLocked) begin
      if (mIdx == 'h02 && d == 'h02) begin mLocked = 1; mIdx = 0; end
      else if (mIdx == 'h07) mSel = d;
      else if (mSel < NDEV) begin
        if (mIdx == 'h30) mAct[mSel] = d & 1;
        if (mIdx == 'h60) mBase[mSel] = (mBase[mSel] & 'hFF) | (d << 8);
        if (mIdx == 'h61) mBase[mSel] = (mBase[mSel] & 'hFF00) | d;
      end
    end
  endfunction

  task automatic compareState(string tag);
    check(cfgMode == !mLocked, {tag, " cfgMode"}, cfgMode, !mLocked);
    for (int i = 0; i < NDEV; i++) begin
      check(devActive[i] == mAct[i][0], {tag, " devActive"}, devActive[i], mAct[i]);
      check(devBase[i*16 +: 16] == mBase[i][15:0], {tag, " devBase"}, devBase[i*16 +: 16], mBase[i]);
      check(devBaseValid[i] == (mBase[i] != 0), {tag, " devBaseValid"}, devBaseValid[i], mBase[i] != 0);
    end
  endtask

  task automatic step(bit wr, bit rd, int addr, int d, string tag);
    @(negedge clk);
    ioWr = wr; ioRd = rd; ioAddr = addr[15:0]; ioWrData = d[7:0];
    #1;
    if (rd) check(ioRdData == mRead(addr), {tag, " read"}, ioRdData, mRead(addr));
    @(posedge clk);
    #1;
    if (wr) mWrite(addr, d);
    compareState(tag);
    ioWr = 0; ioRd = 0;
  endtask

  task automatic wr(int addr, int d, string tag); step(1, 0, addr, d, tag); endtask
  task automatic rd(int addr, string tag); step(0, 1, addr, 0, tag); endtask
  task automatic cfgWr(int idx, int d, string tag); wr(IDXP, idx, tag); wr(DATP, d, tag); endtask
  task automatic cfgRd(int idx, string tag); wr(IDXP, idx, tag); rd(DATP, tag); endtask

  task automatic expectRd(int addr, int exp, string tag);
    @(negedge clk);
    ioRd = 1; ioAddr = addr[15:0];
    #1;
    check(ioRdData == exp[7:0], tag, ioRdData, exp);
    @(posedge clk); #1; ioRd = 0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      failCnt++;
      $display("FAIL watchdog: actual %0d expected <50000", cyc);
      $display("[TB] %0d tests run, %0d failed", runCnt, failCnt);
      $finish;
    end
  end

  initial begin
    foreach (mAct[i]) begin mAct[i] = 0; mBase[i] = 0; end
    repeat (3) @(posedge clk);
    #1;
    compareState("R1 reset");
    rstN = 1;
    @(posedge clk); #1;
    compareState("R1 after reset");

    // locked: data port ignored
    wr(DATP, 'h05, "R4 locked write");
    rd(DATP, "R4 locked read");
    rd(IDXP, "R5 locked index read");
    expectRd(DATP, 'hFF, "R4 locked data read FF");

    // broken key
    wr(IDXP, 'h87, "R3"); wr(IDXP, 'h01, "R3"); wr(IDXP, 'h55, "R3"); wr(IDXP, 'h00, "R3");
    wr(IDXP, 'h55, "R3 broken key stays locked");
    check(cfgMode == 0, "R3 broken key", cfgMode, 0);
    // repeated 0x87 restart, foreign writes interleaved
    wr(IDXP, 'h87, "R3"); wr(IDXP, 'h87, "R3"); wr(IDXP, 'h01, "R3");
    wr(16'h0060, 'h99, "R3 foreign write");
    wr(IDXP, 'h55, "R2"); wr(IDXP, 'h55, "R2 unlock");
    check(cfgMode == 1, "R2 unlocked", cfgMode, 1);

    wr(IDXP, 'h22, "R5");
    expectRd(IDXP, 'h22, "R5 index readback");
    cfgRd('h20, "R6 id hi"); cfgRd('h21, "R6 id lo"); cfgRd('h22, "R6 rev");
    expectRd(DATP, 'h03, "R6 revision value");
    cfgWr('h20, 'h12, "R12 id write"); cfgRd('h20, "R12 id unchanged");
    cfgWr('h22, 'hFF, "R12 rev write"); cfgRd('h22, "R12 rev unchanged");
    expectRd(16'h0100, 'hFF, "R13 foreign read");

    cfgWr('h07, 3, "R7 select 3");
    cfgRd('h07, "R7 readback");
    cfgWr('h30, 'hFF, "R8 activate");
    cfgRd('h30, "R8 readback");
    cfgWr('h60, 'h02, "R9 base hi"); cfgWr('h61, 'h01, "R9 base lo");
    check(devBaseValid[3] == 1, "R9 valid dev3", devBaseValid[3], 1);
    cfgWr('h07, 5, "R7 select 5");
    cfgRd('h30, "R7 bank 5 inactive");
    cfgWr('h61, 'h08, "R9 base lo dev5");
    cfgWr('h30, 'h02, "R8 bit0 only");
    check(devActive[5] == 0, "R8 bit0 only", devActive[5], 0);
    cfgWr('h07, 3, "R7"); cfgRd('h60, "R7 bank 3 kept");

    cfgWr('h07, 20, "R11 out of range select");
    cfgWr('h30, 1, "R11 ignored act"); cfgWr('h60, 'hAA, "R11 ignored base");
    cfgRd('h30, "R11 read 0"); cfgRd('h60, "R11 base read 0");
    cfgRd('h45, "R11 unimplemented");
    expectRd(DATP, 'h00, "R11 unimplemented zero");

    cfgWr('h02, 'h05, "R10 no exit");
    check(cfgMode == 1, "R10 no exit", cfgMode, 1);
    cfgWr('h02, 'h02, "R10 exit");
    check(cfgMode == 0, "R10 exit", cfgMode, 0);
    wr(DATP, 'h00, "R4 locked write after exit");
    rd(DATP, "R4 locked read after exit");

    wr(IDXP, 'h87, "R3"); wr(IDXP, 'h01, "R3"); wr(IDXP, 'h87, "R3");
    wr(IDXP, 'h01, "R3"); wr(IDXP, 'h55, "R3"); wr(IDXP, 'h55, "R3 reprefix unlock");
    check(cfgMode == 1, "R3 reprefix unlock", cfgMode, 1);
    rd(IDXP, "R10 index cleared");
    cfgWr('h07, 3, "R7"); cfgRd('h61, "R4 state kept while locked");

    $display("[TB] %0d tests run, %0d failed", runCnt, failCnt);
    $finish;
  end
endmodule